// File: doc/BRIEF.md
# Shared Interrupt Steering Router

This block takes interrupt set and clear requests from up to 32 bus agents and steers them onto sixteen system IRQ lines. Each request names an agent and one of that agent's four interrupt pins (A to D). A four-entry steering table, written through a small configuration port, gives each pin a target IRQ number and its own trigger-mode bit. An IRQ number of 16 or more disables the pin.

Level-triggered routes can be shared. For every IRQ line the block keeps a mask with one bit per agent that currently holds the line. The line stays asserted until the last holder releases it, and a clear from an agent that holds nothing is dropped. Edge-mode routes do not touch the masks. A set on an edge route gives a single-cycle pulse.

The block also keeps a pair of 8-bit trigger-mode registers, one for IRQ 0–7 and one for IRQ 8–15, and reports the mode of every IRQ on a status vector. These registers can be switched off. The reported mode then follows the level-trigger bit of the primary or secondary interrupt controller's first initialisation word. The reported mode is for the downstream controller only and does not change how requests are steered.

Top module: `irq_steer_router`

## Requirements
- R1: A set request on pin p (`req_pin` 0=A … 3=D) is steered to the IRQ number held in steering entry p. Entry p is written at `cfg_addr` = p, with `cfg_data[4:0]` as the IRQ number.
- R2: A steering entry holding a value of 16 to 31 disables its pin. Requests on that pin change no IRQ output and no hold state.
- R3: A set on a level-mode route records the agent in the target IRQ's hold mask. The IRQ output is high from the cycle after the clock edge that accepts the request.
- R4: A level-mode IRQ output stays high while any agent holds it. It falls in the cycle after the last holder's clear is accepted.
- R5: A clear on a level-mode route from an agent whose bit is not set in the target IRQ's hold mask is ignored.
- R6: A set on an edge-mode route drives the target IRQ output high for exactly one cycle after the accepting edge. A clear on an edge-mode route has no effect on any output.
- R7: Trigger-mode bits are written at `cfg_addr` = 7, with `cfg_data[p]` for pin p (1 = level, 0 = edge). At reset they are all level when `STEER_SUPPORTED` = 1 and all edge otherwise.
- R8: The mode registers are written at `cfg_addr` = 4 (IRQ 0–7, bit n = IRQ n) and `cfg_addr` = 5 (IRQ 8–15, bit n = IRQ 8+n), with 1 = level. While they are enabled, `irq_is_level` shows them two edges after the write is accepted.
- R9: While the mode registers are enabled, IRQ 0, 1, 2, 8 and 13 always report edge (0).
- R10: Writing `cfg_data[0]` = 0 at `cfg_addr` = 6 disables the mode registers. `irq_is_level[7:0]` then follows `pri_ltim` and `irq_is_level[15:8]` follows `sec_ltim`, and writing 1 enables them again.
- R11: Synchronous reset disables all four steering entries and clears every hold mask. It also clears both mode registers, enables them, and drives `irq_out` and `irq_is_level` to zero.
- R12: When a steering-entry write and a request on the same pin arrive in the same cycle, the request uses the entry as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_set | input | 1 | 1 = assert interrupt, 0 = release |
| req_agent | input | AGENT_W (5) | Requesting agent index |
| req_pin | input | 2 | Agent interrupt pin, 0=A … 3=D |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| pri_ltim | input | 1 | Level bit of primary controller's first init word |
| sec_ltim | input | 1 | Level bit of secondary controller's first init word |
| irq_out | output | 16 | Registered system IRQ lines |
| irq_is_level | output | 16 | Registered per-IRQ reported trigger mode |

## Verification
A steering-table write and a request on the same pin can both land on one clock edge. The bench provokes this by driving the entry rewrite and a level-mode set in the same cycle. It then requires the line named by the old entry to rise, and the new target to stay low. A follow-up clear from that agent, now steered to the new target where it holds nothing, must be ignored. This shows that the hold recorded under the old route survived the rewrite.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NUM_IRQ   = 16;
  localparam int IRQ_IDX_W = $clog2(NUM_IRQ);
  localparam int ROUTE_W   = IRQ_IDX_W + 1;
  localparam int NUM_PINS  = 4;
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int CFG_AW    = 3;
  localparam int CFG_DW    = 8;
  localparam int HALF_IRQ  = NUM_IRQ / 2;

  localparam logic [ROUTE_W-1:0] ROUTE_OFF  = '1;
  // IRQs whose reported mode is pinned to edge while the mode registers are on
  localparam logic [NUM_IRQ-1:0] FIXED_EDGE = 16'h2107;

  typedef enum logic [CFG_AW-1:0] {
    CFG_RT_A    = 3'd0,
    CFG_RT_B    = 3'd1,
    CFG_RT_C    = 3'd2,
    CFG_RT_D    = 3'd3,
    CFG_MODE_LO = 3'd4,
    CFG_MODE_HI = 3'd5,
    CFG_MODE_EN = 3'd6,
    CFG_TRIG    = 3'd7
  } cfg_addr_e;
endpackage

// File: rtl/steer_cfg_regs.sv
module steer_cfg_regs
  import irq_steer_pkg::*;
#(
  parameter bit STEER_SUPPORTED = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [CFG_DW-1:0]                 cfg_data,
  output logic [NUM_PINS-1:0][ROUTE_W-1:0]  route_irq,
  output logic [NUM_PINS-1:0]               route_lvl,
  output logic [HALF_IRQ-1:0]               mode_lo,
  output logic [HALF_IRQ-1:0]               mode_hi,
  output logic                              mode_en
);

  cfg_addr_e sel;
  assign sel = cfg_addr_e'(cfg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      route_irq <= {NUM_PINS{ROUTE_OFF}};
      route_lvl <= {NUM_PINS{STEER_SUPPORTED}};
      mode_lo   <= '0;
      mode_hi   <= '0;
      mode_en   <= 1'b1;
    end else if (cfg_we) begin
      case (sel)
        CFG_RT_A, CFG_RT_B, CFG_RT_C, CFG_RT_D:
          route_irq[cfg_addr[PIN_W-1:0]] <= cfg_data[ROUTE_W-1:0];
        CFG_MODE_LO: mode_lo   <= cfg_data[HALF_IRQ-1:0];
        CFG_MODE_HI: mode_hi   <= cfg_data[HALF_IRQ-1:0];
        CFG_MODE_EN: mode_en   <= cfg_data[0];
        CFG_TRIG:    route_lvl <= cfg_data[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  AST_TABLE_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (route_irq == {NUM_PINS{ROUTE_OFF}}) && mode_en
      && (route_lvl == {NUM_PINS{STEER_SUPPORTED}})); // R11

endmodule

// File: rtl/steer_hold_bank.sv
module steer_hold_bank
  import irq_steer_pkg::*;
#(
  parameter int N_AGENTS = 32,
  localparam int AGENT_W = $clog2(N_AGENTS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic                              req_set,
  input  logic [AGENT_W-1:0]                req_agent,
  input  logic [PIN_W-1:0]                  req_pin,
  input  logic [NUM_PINS-1:0][ROUTE_W-1:0]  route_irq,
  input  logic [NUM_PINS-1:0]               route_lvl,
  output logic [NUM_IRQ-1:0]                irq_out
);

  logic [NUM_IRQ-1:0][N_AGENTS-1:0] hold_q, hold_nxt;
  logic [NUM_IRQ-1:0]               pulse;
  logic [ROUTE_W-1:0]               sel_irq;
  logic                             sel_lvl;
  logic                             sel_ok;
  logic [IRQ_IDX_W-1:0]             tgt;

  // Request decode: look up the steering entry of the requesting pin
  assign sel_irq = route_irq[req_pin];
  assign sel_lvl = route_lvl[req_pin];
  assign sel_ok  = sel_irq < ROUTE_W'(NUM_IRQ);
  assign tgt     = sel_irq[IRQ_IDX_W-1:0];

  always_comb begin
    hold_nxt = hold_q;
    pulse    = '0;
    if (req_valid && sel_ok) begin
      if (sel_lvl) begin
        if (req_set)
          hold_nxt[tgt][req_agent] = 1'b1;
        else if (hold_q[tgt][req_agent])
          hold_nxt[tgt][req_agent] = 1'b0;
      end else if (req_set) begin
        pulse[tgt] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      irq_out <= '0;
    end else begin
      hold_q <= hold_nxt;
      for (int i = 0; i < NUM_IRQ; i++)
        irq_out[i] <= (|hold_nxt[i]) | pulse[i];
    end
  end

  AST_OFF_ROUTE_INERT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !sel_ok) |=> $stable(hold_q)); // R2

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line_chk
    AST_HELD_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (hold_q[g] != '0) |-> irq_out[g]); // R4

    AST_DROP_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_out[g]) |-> (hold_q[g] == '0)); // R4

    AST_STRAY_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_set && sel_ok && sel_lvl && (tgt == IRQ_IDX_W'(g))
        && !hold_q[g][req_agent]) |=> $stable(hold_q[g])); // R5

    AST_EDGE_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && irq_out[g] && (hold_q[g] == '0))
        |-> $past(req_valid && req_set && !sel_lvl)); // R6
  end

endmodule

// File: rtl/steer_mode_report.sv
module steer_mode_report
  import irq_steer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [HALF_IRQ-1:0]   mode_lo,
  input  logic [HALF_IRQ-1:0]   mode_hi,
  input  logic                  mode_en,
  input  logic                  pri_ltim,
  input  logic                  sec_ltim,
  output logic [NUM_IRQ-1:0]    irq_is_level
);

  logic [NUM_IRQ-1:0] reg_view, ctl_view, mode_nxt;

  assign reg_view = {mode_hi, mode_lo} & ~FIXED_EDGE;
  assign ctl_view = {{HALF_IRQ{sec_ltim}}, {HALF_IRQ{pri_ltim}}};
  assign mode_nxt = mode_en ? reg_view : ctl_view;

  always_ff @(posedge clk) begin
    if (rst) irq_is_level <= '0;
    else     irq_is_level <= mode_nxt;
  end

  AST_FIXED_STAY_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_en)) |-> ((irq_is_level & FIXED_EDGE) == '0)); // R9

  AST_FALLBACK_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_en))
      |-> (irq_is_level[HALF_IRQ-1:0] == {HALF_IRQ{$past(pri_ltim)}})); // R10

  AST_FALLBACK_SECONDARY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_en))
      |-> (irq_is_level[NUM_IRQ-1:HALF_IRQ] == {HALF_IRQ{$past(sec_ltim)}})); // R10

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int N_AGENTS        = 32,
  parameter bit STEER_SUPPORTED = 1'b1,
  localparam int AGENT_W        = $clog2(N_AGENTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_set,
  input  logic [AGENT_W-1:0]   req_agent,
  input  logic [PIN_W-1:0]     req_pin,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_data,
  input  logic                 pri_ltim,
  input  logic                 sec_ltim,
  output logic [NUM_IRQ-1:0]   irq_out,
  output logic [NUM_IRQ-1:0]   irq_is_level
);

  logic [NUM_PINS-1:0][ROUTE_W-1:0] route_irq;
  logic [NUM_PINS-1:0]              route_lvl;
  logic [HALF_IRQ-1:0]              mode_lo, mode_hi;
  logic                             mode_en;

  steer_cfg_regs #(
    .STEER_SUPPORTED(STEER_SUPPORTED)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data),
    .route_irq (route_irq),
    .route_lvl (route_lvl),
    .mode_lo   (mode_lo),
    .mode_hi   (mode_hi),
    .mode_en   (mode_en)
  );

  steer_hold_bank #(
    .N_AGENTS(N_AGENTS)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_set   (req_set),
    .req_agent (req_agent),
    .req_pin   (req_pin),
    .route_irq (route_irq),
    .route_lvl (route_lvl),
    .irq_out   (irq_out)
  );

  steer_mode_report u_mode (
    .clk          (clk),
    .rst          (rst),
    .mode_lo      (mode_lo),
    .mode_hi      (mode_hi),
    .mode_en      (mode_en),
    .pri_ltim     (pri_ltim),
    .sec_ltim     (sec_ltim),
    .irq_is_level (irq_is_level)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0) && (irq_is_level == '0)); // R11

endmodule

// File: tb/test_irq_steer_router.sv
module test_irq_steer_router;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_set;
  logic [4:0]  req_agent;
  logic [1:0]  req_pin;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        pri_ltim, sec_ltim;
  logic [15:0] irq_out, irq_is_level;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_steer_router i_irq_steer_router (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_set(req_set), .req_agent(req_agent), .req_pin(req_pin),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .pri_ltim(pri_ltim), .sec_ltim(sec_ltim),
    .irq_out(irq_out), .irq_is_level(irq_is_level)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int agent, input int pin, input bit set);
    @(negedge clk);
    req_valid = 1'b1; req_set = set; req_agent = agent[4:0]; req_pin = pin[1:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[2:0]; cfg_data = data[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 irq_out after reset", irq_out, 16'h0000);
    chk("R11 mode after reset", irq_is_level, 16'h0000);
    do_req(1, 0, 1'b1);
    chk("R11 entries disabled after reset", irq_out, 16'h0000);
  endtask

  task automatic t_level_share();
    cfg_wr(0, 10);
    do_req(3, 0, 1'b1);
    chk("R1 R3 level set raises irq10", irq_out, 16'h0400);
    do_req(7, 0, 1'b1);
    chk("R3 second holder", irq_out, 16'h0400);
    do_req(9, 0, 1'b0);
    chk("R5 non-holder clear ignored", irq_out, 16'h0400);
    do_req(3, 0, 1'b0);
    chk("R4 R7 line held by remaining agent", irq_out, 16'h0400);
    do_req(7, 0, 1'b0);
    chk("R4 last holder release drops line", irq_out, 16'h0000);
    do_req(7, 0, 1'b0);
    chk("R5 repeat clear no effect", irq_out, 16'h0000);
  endtask

  task automatic t_edge();
    cfg_wr(7, 8'b1101);
    cfg_wr(1, 4);
    do_req(1, 1, 1'b1);
    chk("R6 edge pulse high", irq_out, 16'h0010);
    @(negedge clk);
    chk("R6 edge pulse one cycle", irq_out, 16'h0000);
    do_req(1, 1, 1'b0);
    chk("R6 edge clear no effect", irq_out, 16'h0000);
    cfg_wr(1, 10);
    do_req(2, 0, 1'b1);
    chk("R3 level hold on irq10", irq_out, 16'h0400);
    do_req(2, 1, 1'b0);
    chk("R6 edge clear leaves held line", irq_out, 16'h0400);
    do_req(2, 0, 1'b0);
    chk("R4 release after edge clear", irq_out, 16'h0000);
  endtask

  task automatic t_disabled();
    cfg_wr(2, 16);
    do_req(4, 2, 1'b1);
    chk("R2 entry 16 disabled", irq_out, 16'h0000);
    cfg_wr(2, 31);
    do_req(4, 2, 1'b1);
    chk("R2 entry 31 disabled", irq_out, 16'h0000);
    cfg_wr(2, 0);
    do_req(4, 2, 1'b0);
    chk("R2 no hold recorded while disabled", irq_out, 16'h0000);
  endtask

  task automatic t_mode();
    cfg_wr(4, 8'hFF);
    cfg_wr(5, 8'hFF);
    @(negedge clk);
    chk("R8 R9 all set with fixed edge", irq_is_level, 16'hDEF8);
    cfg_wr(4, 8'h20);
    cfg_wr(5, 8'h00);
    @(negedge clk);
    chk("R8 single bit IRQ5", irq_is_level, 16'h0020);
    pri_ltim = 1'b1; sec_ltim = 1'b0;
    cfg_wr(6, 0);
    @(negedge clk);
    chk("R10 disabled follows primary", irq_is_level, 16'h00FF);
    pri_ltim = 1'b0; sec_ltim = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 disabled follows secondary", irq_is_level, 16'hFF00);
    cfg_wr(6, 1);
    @(negedge clk);
    chk("R10 re-enabled registers", irq_is_level, 16'h0020);
  endtask

  task automatic t_same_cycle();
    cfg_wr(3, 6);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_data = 8'd9;
    req_valid = 1'b1; req_set = 1'b1; req_agent = 5'd4; req_pin = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R12 request used old entry", irq_out, 16'h0040);
    do_req(4, 3, 1'b0);
    chk("R12 R5 clear on new route ignored", irq_out, 16'h0040);
    cfg_wr(3, 6);
    do_req(4, 3, 1'b0);
    chk("R12 hold kept under old route", irq_out, 16'h0000);
  endtask

  task automatic t_reset_again();
    cfg_wr(0, 3);
    do_req(5, 0, 1'b1);
    chk("R3 hold before reset", irq_out, 16'h0008);
    pri_ltim = 1'b1;
    cfg_wr(6, 0);
    do_reset();
    chk("R11 outputs cleared", irq_out, 16'h0000);
    chk("R11 registers enabled and cleared", irq_is_level, 16'h0000);
    do_req(5, 0, 1'b1);
    chk("R11 entry disabled again", irq_out, 16'h0000);
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_set = 1'b0; req_agent = '0; req_pin = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    pri_ltim = 1'b0; sec_ltim = 1'b0;
    t_reset();
    t_level_share();
    t_edge();
    t_disabled();
    t_mode();
    t_same_cycle();
    t_reset_again();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule